// File: doc/BRIEF.md
# Condition-Gated Integer Execute Stage

This block performs one integer data-processing operation per clock. Each cycle it takes an operation code, a condition selector, a set-flags request, a first operand and an already-shifted second operand with the carry the shifter produced. It also takes the current N, Z, C and V status flags. It produces a result and a destination-write strobe. It also produces the status-flag value the core should hold after the operation, with a flag-write strobe. All outputs are registered, so they appear one clock after the inputs are presented.

The condition selector is checked against the incoming flags before anything else. When the check fails, the operation still uses its cycle, but neither strobe rises and the flag output repeats the incoming flags. Four of the sixteen operations are comparisons or tests. They exist only for their effect on the flags and never request a register write. Subtraction with carry follows the "carry means no borrow" rule, so the carry flag acts as an inverted borrow.

Top module: `cond_alu`

## Requirements
- R1: The 4-bit operation code selects 0 AND, 1 XOR, 2 first minus second, 3 second minus first, 4 add, 5 add plus C, 6 first minus second plus C minus one, 7 second minus first plus C minus one, 8 AND-test, 9 XOR-test, A compare by subtraction, B compare by addition, C OR, D pass second operand, E first AND NOT second, F NOT second. The result is the low 32 bits of that computation.
- R2: The outputs are registered and reflect the inputs of the preceding clock edge. While reset is high, the result, both strobes and the flag output are all zero.
- R3: Codes 8 to B never assert the destination-write strobe. Every other code asserts it exactly when the condition passes.
- R4: For codes 2 to 7, A and B, the carry flag is 1 on carry out of an addition and 1 on the absence of borrow in a subtraction. The overflow flag is 1 when the true signed result does not fit in 32 bits.
- R5: Condition codes 0 to E pass when, respectively: Z; !Z; C; !C; N; !N; V; !V; C&!Z; !C|Z; N==V; N!=V; !Z&(N==V); Z|(N!=V); always. Flag input bits are N=3, Z=2, C=1, V=0, and the flag output uses the same order.
- R6: Condition code F never executes.
- R7: When the condition fails, both strobes stay low and the flag output equals the flag input of that cycle.
- R8: The flag-write strobe rises only for a passing condition with the set-flags bit high or a code from 8 to B. When it stays low, the flag output equals the flag input.
- R9: For codes 0, 1, 8, 9, C, D, E and F, a flag write sets C to the shifter carry input and keeps V at its input value.
- R10: On a flag write, N equals bit 31 of the result and Z is 1 exactly when all 32 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition selector |
| op_i | input | 4 | Operation code |
| setf_i | input | 1 | Request flag update |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Shifter carry out |
| flags_i | input | 4 | Current N, Z, C, V |
| res_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination-write strobe |
| flags_o | output | 4 | Flags after the operation |
| flag_wr_o | output | 1 | Flag-write strobe |

## Verification
The assertions take each input as a known value that holds steady across the sampling edge. Several of them compare the flag output with the flag input one cycle earlier through `$past`, which only holds if nothing changes at the edge. The bench meets this by driving every input on the falling edge and leaving it alone through the following rising edge. The second operand and shifter carry come from outside the block, so they are treated as arbitrary. The sweeps combine them freely with every flag pattern, including values that would never arise together from a real shifter.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Comparison and test codes occupy 8..B
    function automatic logic op_is_compare(alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_logical(alu_op_e op);
        case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cond_alu_gate.sv
module cond_alu_gate
    import cond_alu_pkg::*;
(
    input  cond_e cond,
    input  nzcv_t fl,
    output logic  pass
);
    always_comb begin
        case (cond)
            CC_EQ:   pass = fl.z;
            CC_NE:   pass = !fl.z;
            CC_CS:   pass = fl.c;
            CC_CC:   pass = !fl.c;
            CC_MI:   pass = fl.n;
            CC_PL:   pass = !fl.n;
            CC_VS:   pass = fl.v;
            CC_VC:   pass = !fl.v;
            CC_HI:   pass = fl.c && !fl.z;
            CC_LS:   pass = !fl.c || fl.z;
            CC_GE:   pass = (fl.n == fl.v);
            CC_LT:   pass = (fl.n != fl.v);
            CC_GT:   pass = !fl.z && (fl.n == fl.v);
            CC_LE:   pass = fl.z || (fl.n != fl.v);
            CC_AL:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_alu_core.sv
module cond_alu_core
    import cond_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] rn,
    input  logic [DW-1:0] op2,
    input  logic          c_in,
    output logic [DW-1:0] result,
    output logic          add_c,
    output logic          add_v
);
    localparam int SW = DW + 1;

    logic [DW-1:0] ax, ay;
    logic          aci;
    logic [SW-1:0] sum;
    logic [DW-1:0] logic_res;

    // One shared adder; subtractions invert one operand and supply carry-in
    always_comb begin
        ax  = rn;
        ay  = op2;
        aci = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin ax = rn;  ay = ~op2; aci = 1'b1; end
            OP_RSB:         begin ax = op2; ay = ~rn;  aci = 1'b1; end
            OP_ADC:         begin ax = rn;  ay = op2;  aci = c_in; end
            OP_SBC:         begin ax = rn;  ay = ~op2; aci = c_in; end
            OP_RSC:         begin ax = op2; ay = ~rn;  aci = c_in; end
            default:        begin ax = rn;  ay = op2;  aci = 1'b0; end
        endcase
    end

    assign sum   = {1'b0, ax} + {1'b0, ay} + {{DW{1'b0}}, aci};
    assign add_c = sum[DW];
    assign add_v = (ax[DW-1] == ay[DW-1]) && (sum[DW-1] != ax[DW-1]);

    always_comb begin
        case (op)
            OP_AND, OP_TST: logic_res = rn & op2;
            OP_EOR, OP_TEQ: logic_res = rn ^ op2;
            OP_ORR:         logic_res = rn | op2;
            OP_MOV:         logic_res = op2;
            OP_BIC:         logic_res = rn & ~op2;
            default:        logic_res = ~op2;
        endcase
    end

    assign result = op_is_logical(op) ? logic_res : sum[DW-1:0];
endmodule

// File: rtl/cond_alu_flags.sv
module cond_alu_flags
    import cond_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] result,
    input  logic          add_c,
    input  logic          add_v,
    input  logic          shc,
    input  nzcv_t         old_fl,
    output nzcv_t         new_fl
);
    always_comb begin
        new_fl.n = result[DW-1];
        new_fl.z = (result == '0);
        if (op_is_logical(op)) begin
            new_fl.c = shc;
            new_fl.v = old_fl.v;
        end else begin
            new_fl.c = add_c;
            new_fl.v = add_v;
        end
    end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cond_i,
    input  logic [3:0]    op_i,
    input  logic          setf_i,
    input  logic [DW-1:0] rn_i,
    input  logic [DW-1:0] op2_i,
    input  logic          shc_i,
    input  logic [3:0]    flags_i,
    output logic [DW-1:0] res_o,
    output logic          wr_en_o,
    output logic [3:0]    flags_o,
    output logic          flag_wr_o
);
    alu_op_e       op;
    nzcv_t         cur_fl, new_fl;
    logic          cond_pass, is_cmp, is_logic;
    logic [DW-1:0] result;
    logic          add_c, add_v;
    logic          wr_d, fw_d;
    nzcv_t         fl_d;

    assign op       = alu_op_e'(op_i);
    assign cur_fl   = nzcv_t'(flags_i);
    assign is_cmp   = op_is_compare(op);
    assign is_logic = op_is_logical(op);

    cond_alu_gate u_gate (
        .cond (cond_e'(cond_i)),
        .fl   (cur_fl),
        .pass (cond_pass)
    );

    cond_alu_core #(.DW(DW)) u_core (
        .op     (op),
        .rn     (rn_i),
        .op2    (op2_i),
        .c_in   (cur_fl.c),
        .result (result),
        .add_c  (add_c),
        .add_v  (add_v)
    );

    cond_alu_flags #(.DW(DW)) u_flags (
        .op     (op),
        .result (result),
        .add_c  (add_c),
        .add_v  (add_v),
        .shc    (shc_i),
        .old_fl (cur_fl),
        .new_fl (new_fl)
    );

    assign wr_d = cond_pass && !is_cmp;
    assign fw_d = cond_pass && (setf_i || is_cmp);
    assign fl_d = fw_d ? new_fl : cur_fl;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o     <= '0;
            wr_en_o   <= 1'b0;
            flags_o   <= '0;
            flag_wr_o <= 1'b0;
        end else begin
            res_o     <= result;
            wr_en_o   <= wr_d;
            flags_o   <= fl_d;
            flag_wr_o <= fw_d;
        end
    end

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        is_cmp |=> !wr_en_o);

    a_r6_never_cond: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'hF) |=> (!wr_en_o && !flag_wr_o));

    a_r7_fail_holds: assert property (@(posedge clk) disable iff (rst)
        !cond_pass |=> (!wr_en_o && !flag_wr_o && flags_o == $past(flags_i)));

    a_r8_no_setf: assert property (@(posedge clk) disable iff (rst)
        (!setf_i && !is_cmp) |=> (!flag_wr_o && flags_o == $past(flags_i)));

    a_r9_logic_v_kept: assert property (@(posedge clk) disable iff (rst)
        is_logic |=> (flags_o[0] == $past(flags_i[0])));

    a_r10_nz_track: assert property (@(posedge clk) disable iff (rst)
        flag_wr_o |-> (flags_o[3] == res_o[DW-1] && flags_o[2] == (res_o == '0)));

endmodule

// File: tb/cond_alu_bench.sv
`timescale 1ns/1ps
module cond_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cond_i = 4'hE;
    logic [3:0]  op_i = 4'h0;
    logic        setf_i = 1'b0;
    logic [31:0] rn_i = '0;
    logic [31:0] op2_i = '0;
    logic        shc_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [31:0] res_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;
    logic        flag_wr_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cond_alu u_cond_alu (
        .clk(clk), .rst(rst), .cond_i(cond_i), .op_i(op_i), .setf_i(setf_i),
        .rn_i(rn_i), .op2_i(op2_i), .shc_i(shc_i), .flags_i(flags_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .flag_wr_o(flag_wr_o)
    );

    logic [31:0] vals [6] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit cc_ok(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic void model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] f, input logic sh,
                                  output logic [31:0] r, output logic [3:0] nf);
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ci = longint'({63'd0, f[1]});
        longint u = 0, s = 0;
        bit is_sub = 1'b0, is_arith = 1'b1, c, v;
        case (o)
            4'h2, 4'hA: begin u = ua - ub; s = sa - sb; is_sub = 1'b1; end
            4'h3:       begin u = ub - ua; s = sb - sa; is_sub = 1'b1; end
            4'h4, 4'hB: begin u = ua + ub; s = sa + sb; end
            4'h5:       begin u = ua + ub + ci; s = sa + sb + ci; end
            4'h6:       begin u = ua - ub - (1 - ci); s = sa - sb - (1 - ci); is_sub = 1'b1; end
            4'h7:       begin u = ub - ua - (1 - ci); s = sb - sa - (1 - ci); is_sub = 1'b1; end
            default:    is_arith = 1'b0;
        endcase
        if (is_arith) begin
            r = u[31:0];
            c = is_sub ? (u >= 0) : (u >= 64'sh1_0000_0000);
            v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            case (o)
                4'h0, 4'h8: r = a & b;
                4'h1, 4'h9: r = a ^ b;
                4'hC:       r = a | b;
                4'hD:       r = b;
                4'hE:       r = a & ~b;
                default:    r = ~b;
            endcase
            c = sh;
            v = f[0];
        end
        nf = {r[31], (r == 32'd0), c, v};
    endfunction

    task automatic drive(input logic [3:0] c, input logic [3:0] o, input logic s,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic sh, input logic [3:0] f);
        @(negedge clk);
        cond_i = c; op_i = o; setf_i = s; rn_i = a; op2_i = b; shc_i = sh; flags_i = f;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        logic [3:0]  ef;
        bit          p, cmp;

        // R2: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset res", res_o, 0);
        chk("R2 reset wr_en", wr_en_o, 0);
        chk("R2 reset flags", flags_o, 0);
        chk("R2 reset flag_wr", flag_wr_o, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: one-cycle latency, output unchanged before the edge
        drive(4'hE, 4'hD, 1'b0, 32'h0, 32'h0000_00A5, 1'b0, 4'h0);
        @(negedge clk);
        op2_i = 32'h0000_005A;
        #1;
        chk("R2 before edge", res_o, 32'h0000_00A5);
        @(posedge clk);
        #1;
        chk("R2 after edge", res_o, 32'h0000_005A);

        // R5 R6 R7: every condition against every flag pattern
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                drive(cc[3:0], 4'h4, 1'b1, 32'h5, 32'h3, 1'b0, f[3:0]);
                p = cc_ok(cc[3:0], f[3:0]);
                model(4'h4, 32'h5, 32'h3, f[3:0], 1'b0, er, ef);
                chk(cc == 15 ? "R6 never wr_en" : "R5 cond wr_en", wr_en_o, p);
                chk(cc == 15 ? "R6 never flag_wr" : "R5 cond flag_wr", flag_wr_o, p);
                chk("R7 flags on cond", flags_o, p ? ef : f[3:0]);
            end
        end

        // R1 R3 R4 R9 R10: all opcodes over corner operands
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [3:0] f = {k[1], k[0], k[0], k[1]};
                        logic sh = k[0] ^ k[1];
                        drive(4'hE, o[3:0], 1'b1, vals[i], vals[j], sh, f);
                        model(o[3:0], vals[i], vals[j], f, sh, er, ef);
                        cmp = (o >= 8 && o <= 11);
                        chk("R1 result", res_o, er);
                        chk("R3 write strobe", wr_en_o, !cmp);
                        chk("R10 N and Z", flags_o[3:2], ef[3:2]);
                        if ((o >= 2 && o <= 7) || o == 10 || o == 11)
                            chk("R4 C and V", flags_o[1:0], ef[1:0]);
                        else
                            chk("R9 C and V", flags_o[1:0], ef[1:0]);
                    end
                end
            end
        end

        // R8: set-flags low leaves flags alone except for compares
        for (int o = 0; o < 16; o++) begin
            for (int k = 0; k < 4; k++) begin
                logic [3:0] f = k[0] ? 4'b1010 : 4'b0101;
                drive(4'hE, o[3:0], 1'b0, vals[k + 1], vals[5 - k], k[1], f);
                model(o[3:0], vals[k + 1], vals[5 - k], f, k[1], er, ef);
                cmp = (o >= 8 && o <= 11);
                chk("R8 flag_wr", flag_wr_o, cmp);
                chk("R8 flags", flags_o, cmp ? ef : f);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule